// File: doc/BRIEF.md
# Serial Read-Out Front End for Power-Up SRAM Fingerprints

This block sits between a slow serial host link and a bank of eleven single-port SRAM instances whose power-up contents serve as a physical fingerprint. The host raises a chip-select and clocks in a 15-bit command, most significant bit first. The command names one memory and one word address. The block then issues exactly one read strobe to that memory and returns a 70-bit reply on its serial output. The reply carries a three-bit leading marker, the 64-bit word, and a three-bit trailing marker.

The block has no write path of any kind toward the memories, so their start-up state survives every read. Memories narrower than 64 bits are declared through a per-bank width parameter. Their unused upper bits are returned as zeros. A busy flag covers the whole reply, and the serial input is ignored while it is high.

Top module: `puf_serial_reader`

## Requirements
- R1: While `cs` is high and `busy` is low, `sdi` is sampled on each rising clock edge, most significant bit first. The 15 bits form a command whose upper 4 bits (14:11) select the memory and whose lower 11 bits (10:0) are the word address.
- R2: `sdo` carries the first reply bit in the cycle that follows the edge sampling the 15th command bit. One reply bit follows per cycle, 70 bits in all.
- R3: The reply starts with the marker bits 1, 0, 1 and ends with the marker bits 0, 1, 0.
- R4: Reply bits 3 to 66 carry the selected 64-bit word, most significant bit first.
- R5: For a memory declared narrower than 64 bits in `BANK_WIDTHS` (8 bits per bank, bank 0 in the lowest byte), the bits above its width are sent as 0.
- R6: Select codes 11 to 15 produce an all-zero data field and no read strobe.
- R7: A valid command raises exactly one bit of `mem_rd_en` for one cycle, the same cycle that `busy` rises, with `mem_addr` equal to the command address. The block never presents more than one strobe bit at a time.
- R8: `busy` rises together with the first reply bit and stays high for exactly 70 cycles, falling after the last trailing marker bit. Any `cs`/`sdi` activity during that time has no effect.
- R9: While `busy` is low, `sdo` is 1. After reset, `busy` is 0, `sdo` is 1 and `mem_rd_en` is all zero.
- R10: Dropping `cs` before the 15th bit discards the partial command, and no reply follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Host select, high while a command is shifted in |
| sdi | input | 1 | Serial command bit |
| sdo | output | 1 | Serial reply bit, high when idle |
| busy | output | 1 | High while a reply is in progress |
| mem_rd_en | output | NUM_BANKS | One-hot read strobe, one bit per memory |
| mem_addr | output | ADDR_W | Word address to the memories |
| mem_rdata | input | NUM_BANKS*WORD_W | Read data of all memories, bank 0 in the lowest slice |

## Verification
The bench builds the block with the default eleven banks and 64-bit words. It sets `BANK_WIDTHS` so that banks 1, 2 and 3 are 32, 16 and 8 bits wide and the others are full width. This mix lets a single run observe zero-padding at three different cut points next to full-width replies. It also lets the run compare the top address 2047 against the strobe address, and use select codes above ten to confirm that no strobe is raised and the data field is zero.

// File: rtl/puf_rd_pkg.sv
package puf_rd_pkg;
    localparam int DEF_BANKS  = 11;
    localparam int DEF_SEL_W  = 4;
    localparam int DEF_ADDR_W = 11;
    localparam int DEF_WORD_W = 64;
    localparam int MARK_W     = 3;
    localparam logic [MARK_W-1:0] LEAD_MARK  = 3'b101;
    localparam logic [MARK_W-1:0] TRAIL_MARK = 3'b010;
endpackage

// File: rtl/puf_cmd_rx.sv
module puf_cmd_rx #(
    parameter int CMD_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             sdi,
    input  logic             hold,
    output logic             launch,
    output logic [CMD_W-1:0] cmd
);
    localparam int CNT_W = $clog2(CMD_W);

    typedef struct packed {
        logic [CMD_W-2:0] sh;
        logic [CNT_W-1:0] cnt;
    } rx_t;

    rx_t q, d;

    always_comb begin
        d      = q;
        launch = 1'b0;
        cmd    = {q.sh, sdi};
        if (!hold) begin
            if (!cs) begin
                d.cnt = '0;
            end else if (q.cnt == CNT_W'(CMD_W - 1)) begin
                launch = 1'b1;
                d.cnt  = '0;
            end else begin
                d.sh  = {q.sh[CMD_W-3:0], sdi};
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/puf_bank_port.sv
module puf_bank_port #(
    parameter int NUM_BANKS = 11,
    parameter int SEL_W     = 4,
    parameter int ADDR_W    = 11,
    parameter int WORD_W    = 64,
    parameter logic [NUM_BANKS*8-1:0] BANK_WIDTHS = {NUM_BANKS{8'd64}}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        launch,
    input  logic [SEL_W-1:0]            sel,
    input  logic [ADDR_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]        mem_rd_en,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic [NUM_BANKS*WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0]           word
);
    typedef struct packed {
        logic [NUM_BANKS-1:0] rd_en;
        logic [ADDR_W-1:0]    addr;
        logic [SEL_W-1:0]     sel;
        logic                 sel_ok;
    } port_t;

    port_t q, d;

    always_comb begin
        d       = q;
        d.rd_en = '0;
        if (launch) begin
            d.sel    = sel;
            d.addr   = addr;
            d.sel_ok = (int'(sel) < NUM_BANKS);
            d.rd_en  = d.sel_ok ? (NUM_BANKS'(1) << sel) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic [WORD_W-1:0] masked [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BW = int'(BANK_WIDTHS[b*8 +: 8]);
        logic [WORD_W-1:0] keep;
        always_comb begin
            for (int j = 0; j < WORD_W; j++) keep[j] = (j < BW);
        end
        assign masked[b] = mem_rdata[b*WORD_W +: WORD_W] & keep;
    end

    always_comb begin
        word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (q.sel_ok && (q.sel == SEL_W'(b))) word = masked[b];
        end
    end

    assign mem_rd_en = q.rd_en;
    assign mem_addr  = q.addr;
endmodule

// File: rtl/puf_frame_tx.sv
module puf_frame_tx
    import puf_rd_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [WORD_W-1:0] word,
    output logic              sdo,
    output logic              busy
);
    localparam int FRAME_W  = WORD_W + 2 * MARK_W;
    localparam int IDX_W    = $clog2(FRAME_W + 1);
    localparam int LOAD_IDX = MARK_W - 1;

    typedef struct packed {
        logic              busy;
        logic              sdo;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } tx_t;

    tx_t q, d;
    int  i;
    logic bit_v;

    always_comb begin
        i = int'(q.idx);
        if (i < MARK_W)               bit_v = LEAD_MARK[MARK_W-1-i];
        else if (i < MARK_W + WORD_W) bit_v = q.data[WORD_W-1-(i-MARK_W)];
        else if (i < FRAME_W)         bit_v = TRAIL_MARK[FRAME_W-1-i];
        else                          bit_v = 1'b1;
    end

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (launch) begin
                d.busy = 1'b1;
                d.sdo  = LEAD_MARK[MARK_W-1];
                d.idx  = IDX_W'(1);
            end
        end else if (q.idx == IDX_W'(FRAME_W)) begin
            d.busy = 1'b0;
            d.sdo  = 1'b1;
            d.idx  = '0;
        end else begin
            d.sdo = bit_v;
            d.idx = q.idx + 1'b1;
            if (q.idx == IDX_W'(LOAD_IDX)) d.data = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sdo: 1'b1, idx: '0, data: '0};
        else        q <= d;
    end

    assign sdo  = q.sdo;
    assign busy = q.busy;
endmodule

// File: rtl/puf_serial_reader.sv
module puf_serial_reader
    import puf_rd_pkg::*;
#(
    parameter int NUM_BANKS = DEF_BANKS,
    parameter int SEL_W     = DEF_SEL_W,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int WORD_W    = DEF_WORD_W,
    parameter logic [NUM_BANKS*8-1:0] BANK_WIDTHS = {NUM_BANKS{8'd64}}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs,
    input  logic                        sdi,
    output logic                        sdo,
    output logic                        busy,
    output logic [NUM_BANKS-1:0]        mem_rd_en,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic [NUM_BANKS*WORD_W-1:0] mem_rdata
);
    localparam int CMD_W = SEL_W + ADDR_W;

    logic             launch;
    logic [CMD_W-1:0] cmd;
    logic [WORD_W-1:0] word;

    puf_cmd_rx #(.CMD_W(CMD_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs),
        .sdi    (sdi),
        .hold   (busy),
        .launch (launch),
        .cmd    (cmd)
    );

    puf_bank_port #(
        .NUM_BANKS   (NUM_BANKS),
        .SEL_W       (SEL_W),
        .ADDR_W      (ADDR_W),
        .WORD_W      (WORD_W),
        .BANK_WIDTHS (BANK_WIDTHS)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .sel       (cmd[CMD_W-1 -: SEL_W]),
        .addr      (cmd[ADDR_W-1:0]),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .word      (word)
    );

    puf_frame_tx #(.WORD_W(WORD_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .word   (word),
        .sdo    (sdo),
        .busy   (busy)
    );
endmodule

// File: rtl/puf_serial_reader_chk.sv
module puf_serial_reader_chk #(
    parameter int NUM_BANKS = 11,
    parameter int FRAME_W   = 70
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 sdo,
    input logic [NUM_BANKS-1:0] mem_rd_en
);
    logic [7:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt_q <= '0;
        else if (busy) busy_cnt_q <= busy_cnt_q + 1'b1;
        else           busy_cnt_q <= '0;
    end

    a_r7_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_rd_en));

    a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_rd_en) |=> (mem_rd_en == '0));

    a_r7_strobe_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_rd_en) |-> $rose(busy));

    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sdo);

    a_r3_lead_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sdo);

    a_r3_trail_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(sdo));

    a_r8_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt_q == 8'(FRAME_W)));
endmodule

bind puf_serial_reader puf_serial_reader_chk #(
    .NUM_BANKS (NUM_BANKS),
    .FRAME_W   (WORD_W + 6)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sdo       (sdo),
    .mem_rd_en (mem_rd_en)
);

// File: tb/puf_serial_reader_test.sv
module puf_serial_reader_test;
    localparam int NB = 11;
    localparam int AW = 11;
    localparam int WW = 64;
    localparam int FW = 70;
    localparam int DEPTH = 64;
    localparam logic [NB*8-1:0] WIDTHS = {{7{8'd64}}, 8'd8, 8'd16, 8'd32, 8'd64};
    localparam int TB_W [NB] = '{64, 32, 16, 8, 64, 64, 64, 64, 64, 64, 64};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sdi = 1'b0;
    logic sdo, busy;
    logic [NB-1:0] mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [NB*WW-1:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [WW-1:0] mem [NB][DEPTH];
    logic [FW-1:0] exp_q [$];

    int            strobe_cnt = 0;
    logic [AW-1:0] strobe_addr = '0;
    logic [NB-1:0] strobe_bank = '0;

    always #2.5 clk = ~clk;

    puf_serial_reader #(.BANK_WIDTHS(WIDTHS)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .sdi       (sdi),
        .sdo       (sdo),
        .busy      (busy),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata)
    );

    // behavioural memories, contents fixed at start-up, read only
    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++)
            if (mem_rd_en[b]) mem_rdata[b*WW +: WW] <= mem[b][mem_addr[5:0]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FW-1:0] act, input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] exp_word(input int sel, input int addr);
        logic [WW-1:0] m;
        if (sel >= NB) return '0;
        m = (TB_W[sel] == WW) ? '1 : ((64'd1 << TB_W[sel]) - 64'd1);
        return mem[sel][addr % DEPTH] & m;
    endfunction

    // monitor: collects every reply and compares it with the scoreboard
    initial begin : monitor
        logic [FW-1:0] got;
        logic [FW-1:0] exp;
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (busy && !prev) begin
                got[FW-1] = sdo;
                for (int k = 1; k < FW; k++) begin
                    @(negedge clk);
                    got[FW-1-k] = sdo;
                end
                check(busy == 1'b1, "R8", "busy during last bit", FW'(busy), FW'(1));
                @(negedge clk);
                check(busy == 1'b0 && sdo == 1'b1, "R9", "idle after reply",
                      FW'({busy, sdo}), FW'(2'b01));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected reply", got, '0);
                end else begin
                    exp = exp_q.pop_front();
                    check(got[FW-1 -: 3] == 3'b101, "R3", "lead marker", FW'(got[FW-1 -: 3]), FW'(3'b101));
                    check(got[2:0] == 3'b010, "R3", "trail marker", FW'(got[2:0]), FW'(3'b010));
                    check(got == exp, "R4", "reply frame", got, exp);
                end
                prev = 1'b0;
            end else begin
                prev = busy;
            end
        end
    end

    // strobe recorder
    initial begin : strobes
        forever begin
            @(negedge clk);
            if (|mem_rd_en) begin
                strobe_cnt++;
                strobe_addr = mem_addr;
                strobe_bank = mem_rd_en;
            end
        end
    end

    task automatic shift_bits(input logic [14:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs  = 1'b1;
            sdi = v[14-i];
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_strobe(input int sel, input int addr, input string req);
        if (sel < NB) begin
            check(strobe_cnt == 1, req, "strobe count", FW'(strobe_cnt), FW'(1));
            check(strobe_bank == NB'(1) << sel, req, "strobe bank", FW'(strobe_bank), FW'(NB'(1) << sel));
            check(strobe_addr == AW'(addr), req, "strobe address", FW'(strobe_addr), FW'(addr));
        end else begin
            check(strobe_cnt == 0, "R6", "no strobe for bad select", FW'(strobe_cnt), FW'(0));
        end
    endtask

    // driver: R1 command, R2 reply timing
    task automatic run_cmd(input int sel, input int addr, input string req);
        logic [14:0] c;
        c = {4'(sel), 11'(addr)};
        exp_q.push_back({3'b101, exp_word(sel, addr), 3'b010});
        strobe_cnt = 0;
        shift_bits(c, 15);
        @(negedge clk);
        cs = 1'b0;
        check(busy == 1'b1, "R2", "busy one cycle after last bit", FW'(busy), FW'(1));
        wait_idle();
        check_strobe(sel, addr, req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        for (int b = 0; b < NB; b++)
            for (int a = 0; a < DEPTH; a++)
                mem[b][a] = {32'(b * 32'h9E3779B9 ^ a * 32'h85EBCA6B) | 32'h8000_0001,
                             32'(a * 32'hC2B2AE35 + b * 32'h27D4EB2F) | 32'h8000_8081};

        repeat (3) @(negedge clk);
        // R9 reset state
        check(busy == 1'b0, "R9", "reset busy", FW'(busy), FW'(0));
        check(sdo == 1'b1, "R9", "reset sdo", FW'(sdo), FW'(1));
        check(mem_rd_en == '0, "R9", "reset strobe", FW'(mem_rd_en), FW'(0));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_cmd(0, 5, "R1");          // full-width bank
        run_cmd(1, 17, "R5");         // 32-bit bank
        run_cmd(2, 63, "R5");         // 16-bit bank
        run_cmd(3, 0, "R5");          // 8-bit bank
        run_cmd(10, 2047, "R7");      // last bank, top address
        run_cmd(7, 1234, "R4");
        run_cmd(11, 9, "R6");         // invalid select codes
        run_cmd(15, 2047, "R6");

        // R8: activity during a reply must not start or corrupt anything
        begin
            logic [14:0] c;
            c = {4'd4, 11'd33};
            exp_q.push_back({3'b101, exp_word(4, 33), 3'b010});
            strobe_cnt = 0;
            shift_bits(c, 15);
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                cs  = 1'b1;
                sdi = k[0] ^ k[2];
            end
            @(negedge clk);
            cs = 1'b0;
            wait_idle();
            check(strobe_cnt == 1, "R8", "no strobe from input during reply", FW'(strobe_cnt), FW'(1));
        end
        run_cmd(5, 100, "R8");

        // R10: partial command aborted by dropping select
        shift_bits({4'd6, 11'd77}, 7);
        @(negedge clk);
        cs = 1'b0;
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R10", "no reply after partial command", FW'(busy), FW'(0));
        run_cmd(6, 77, "R10");

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2", "replies outstanding", FW'(exp_q.size()), FW'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule